// File: doc/BRIEF.md
# Interrupt Pattern Obfuscation Codec

This block sits on the path from an accelerator's layer-completion interrupt to the host. A plain level pulse per layer would show the layer count and timing to anyone who watches the wire. Instead, the interrupt line toward the host carries a continuous stream of four-symbol frames. A frame that carries a real event holds the word `0001`. Every other frame holds a decoy word, picked by a small LFSR. So the line keeps toggling whether the accelerator is busy or not, and a real event is visible only as a rising edge on the fourth symbol of a frame.

The encoder detects each rising edge of the accelerator interrupt and counts it in a saturating pending counter. At the next frame boundary it emits one marker frame for each counted event. The decoder shares the free-running 2-bit symbol counter with the encoder. It gathers the four symbols of each frame and raises a one-cycle host interrupt during the marker symbol of every `0001` frame. That moment is three cycles after the frame's first symbol. Both halves live in one top module, and the encoded line is brought out so it can be routed or observed.

Top module: `irq_obf_top`

## Requirements
- R1: While `rst_n` is low, `line_o` and `host_irq_o` are 0. After reset is released, the symbol phase is 0 in the first cycle and no queued event survives a reset.
- R2: An event is a low-to-high change of `acc_irq_i` between two consecutive rising clock edges. A level held high for many cycles is a single event.
- R3: The symbol phase counts 0,1,2,3 repeatedly from reset release, so frames occupy cycles 4k..4k+3. Each frame word is shifted onto `line_o` MSB first, one bit per cycle.
- R4: At each frame boundary, one event is served if the pending count is non-zero or if an event is seen in that same last cycle. The next frame then carries the marker word `0001`. Events are served one per frame.
- R5: The pending count holds at most 2^PEND_W-1 events (7 by default). Events that arrive while it is full are dropped.
- R6: A frame with no event carries a decoy word from {`0110`, `1000`, `1011`, `0100`}, indexed by the two low LFSR bits. It is never `0001`. The LFSR steps once per frame, so idle frames vary.
- R7: `host_irq_o` is high for exactly one cycle, in the fourth cycle of each frame that carries `0001`. That is three cycles after the frame's first symbol. Decoy frames never raise it.
- R8: When no events are dropped, the number of `host_irq_o` pulses equals the number of events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_irq_i | input | 1 | Level interrupt from the accelerator, one rise per finished layer |
| line_o | output | 1 | Encoded serial interrupt line toward the host |
| host_irq_o | output | 1 | Recovered single-cycle host interrupt |

## Verification
An event sampled at a clock edge is served at the first edge where the symbol phase is 3. Its marker then fills the next four cycles, and `host_irq_o` is due in the fourth of those cycles: four cycles after that serving edge, or three cycles after the frame's first symbol. The bench keeps its own cycle index from reset release, a pending count and a ring of due cycles. It samples both outputs at every falling edge and compares `host_irq_o` with the due ring in every cycle. At phase 3 it compares the four collected line bits with either the marker or the decoy set.

// File: rtl/irq_obf_pkg.sv
package irq_obf_pkg;
  localparam int SYM_W     = 2;
  localparam int FRAME_LEN = 4;

  typedef logic [FRAME_LEN-1:0] word_t;
  typedef logic [SYM_W-1:0]     sym_t;

  localparam word_t MARKER_WORD = 4'b0001;
  localparam sym_t  SYM_LAST    = sym_t'(FRAME_LEN - 1);

  // decoy word for an idle frame; none equals the marker
  function automatic word_t decoy_word(input logic [1:0] idx);
    case (idx)
      2'd0:    return 4'b0110;
      2'd1:    return 4'b1000;
      2'd2:    return 4'b1011;
      default: return 4'b0100;
    endcase
  endfunction

  // symbol shown on the line for a given phase, MSB first
  function automatic logic pick_symbol(input word_t w, input sym_t sym);
    return w[SYM_LAST - sym];
  endfunction

  // pending count update: serve first, then add, then clamp
  function automatic int unsigned pend_step(input int unsigned cur,
                                            input logic take,
                                            input logic rise,
                                            input int unsigned cap);
    int unsigned v;
    v = cur - (take ? 1 : 0) + (rise ? 1 : 0);
    if (v > cap) v = cap;
    return v;
  endfunction
endpackage

// File: rtl/irq_obf_symclk.sv
module irq_obf_symclk
  import irq_obf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output sym_t sym_o
);
  sym_t cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + sym_t'(1);
  end

  assign sym_o = cnt_q;
endmodule

// File: rtl/irq_obf_enc.sv
module irq_obf_enc
  import irq_obf_pkg::*;
#(
  parameter int                PEND_W    = 3,
  parameter int                LFSR_W    = 8,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 8'h5A,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sym_t              sym_i,
  input  logic              acc_irq_i,
  output logic              line_o,
  output logic              ev_rise_o,
  output logic [PEND_W-1:0] pend_o
);
  localparam int unsigned PEND_MAX = (1 << PEND_W) - 1;

  logic              irq_q;
  logic [PEND_W-1:0] pend_q;
  logic [LFSR_W-1:0] lfsr_q;
  word_t             word_q;

  logic ev_rise;
  logic frame_edge;
  logic take;

  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] x);
    return x[0] ? ((x >> 1) ^ LFSR_TAPS) : (x >> 1);
  endfunction

  assign ev_rise    = acc_irq_i & ~irq_q;
  assign frame_edge = (sym_i == SYM_LAST);
  assign take       = frame_edge & ((pend_q != '0) | ev_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      pend_q <= '0;
      lfsr_q <= LFSR_SEED;
      word_q <= decoy_word(2'd0);
    end else begin
      irq_q  <= acc_irq_i;
      pend_q <= PEND_W'(pend_step(int'(pend_q), take, ev_rise, PEND_MAX));
      if (frame_edge) begin
        lfsr_q <= lfsr_next(lfsr_q);
        word_q <= take ? MARKER_WORD : decoy_word(lfsr_q[1:0]);
      end
    end
  end

  assign line_o    = pick_symbol(word_q, sym_i);
  assign ev_rise_o = ev_rise;
  assign pend_o    = pend_q;
endmodule

// File: rtl/irq_obf_dec.sv
module irq_obf_dec
  import irq_obf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  sym_t sym_i,
  input  logic line_i,
  output logic host_irq_o
);
  logic [FRAME_LEN-2:0] hist_q;
  word_t                frame_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= {hist_q[FRAME_LEN-3:0], line_i};
  end

  assign frame_word = {hist_q, line_i};
  assign host_irq_o = (sym_i == SYM_LAST) && (frame_word == MARKER_WORD);
endmodule

// File: rtl/irq_obf_top.sv
module irq_obf_top
  import irq_obf_pkg::*;
#(
  parameter int                PEND_W    = 3,
  parameter int                LFSR_W    = 8,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 8'h5A,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_irq_i,
  output logic line_o,
  output logic host_irq_o
);
  sym_t              sym_cnt;
  logic              ev_rise;
  logic [PEND_W-1:0] pend_cnt;

  irq_obf_symclk u_sym (
    .clk   (clk),
    .rst_n (rst_n),
    .sym_o (sym_cnt)
  );

  irq_obf_enc #(
    .PEND_W    (PEND_W),
    .LFSR_W    (LFSR_W),
    .LFSR_SEED (LFSR_SEED),
    .LFSR_TAPS (LFSR_TAPS)
  ) u_enc (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_i     (sym_cnt),
    .acc_irq_i (acc_irq_i),
    .line_o    (line_o),
    .ev_rise_o (ev_rise),
    .pend_o    (pend_cnt)
  );

  irq_obf_dec u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .sym_i      (sym_cnt),
    .line_i     (line_o),
    .host_irq_o (host_irq_o)
  );
endmodule

// File: rtl/irq_obf_chk.sv
module irq_obf_chk #(
  parameter int PEND_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        sym_cnt,
  input logic [PEND_W-1:0] pend_cnt,
  input logic              ev_rise,
  input logic              line_o,
  input logic              host_irq_o
);
  localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

  assert_phase_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> sym_cnt == $past(sym_cnt) + 2'd1);

  assert_pend_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rise && sym_cnt != 2'd3 && pend_cnt != PEND_MAX) |=> pend_cnt == $past(pend_cnt) + 1'b1);

  assert_serve_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_cnt == 2'd3 && (pend_cnt != '0 || ev_rise)) |=> ##3 host_irq_o);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rise && sym_cnt != 2'd3 && pend_cnt == PEND_MAX) |=> pend_cnt == PEND_MAX);

  assert_decoy_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_cnt == 2'd3 && pend_cnt == '0 && !ev_rise) |=> ##3 !host_irq_o);

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq_o |=> !host_irq_o);

  assert_pulse_marker_R7: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq_o |-> (line_o && sym_cnt == 2'd3 &&
                    !$past(line_o, 1) && !$past(line_o, 2) && !$past(line_o, 3)));
endmodule

bind irq_obf_top irq_obf_chk #(.PEND_W(PEND_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sym_cnt    (sym_cnt),
  .pend_cnt   (pend_cnt),
  .ev_rise    (ev_rise),
  .line_o     (line_o),
  .host_irq_o (host_irq_o)
);

// File: tb/tb_irq_obf_top.sv
`timescale 1ns/1ps
module tb_irq_obf_top;
  localparam int PEND_CAP = 7;
  localparam int NVEC     = 8;
  localparam int FLUSH    = 40;

  localparam logic [15:0] STIM  [NVEC] = '{16'h0000, 16'h00F0, 16'hFFFF, 16'hAAAA,
                                           16'h8421, 16'hCCCC, 16'h0101, 16'hF00F};
  localparam int          RISES [NVEC] = '{0, 1, 1, 8, 4, 4, 2, 2};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_irq = 1'b0;
  logic line_o;
  logic host_irq_o;

  irq_obf_top dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_irq_i  (acc_irq),
    .line_o     (line_o),
    .host_irq_o (host_irq_o)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int n;
  int pend;
  bit prev_v;
  bit cur_marker;
  bit due [8];
  logic [3:0] fbits;
  int pulses, exp_pulses, rises_seen;
  bit [15:0] seen_mask;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit is_decoy(input logic [3:0] w);
    return (w == 4'b0110) || (w == 4'b1000) || (w == 4'b1011) || (w == 4'b0100);
  endfunction

  task automatic model_clear();
    n = 0; pend = 0; prev_v = 0; cur_marker = 0; fbits = '0;
    for (int i = 0; i < 8; i++) due[i] = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    acc_irq = 1'b0;
    repeat (3) @(negedge clk);
    chk(line_o == 1'b0, "R1 line in reset", int'(line_o), 0);
    chk(host_irq_o == 1'b0, "R1 host irq in reset", int'(host_irq_o), 0);
    rst_n = 1'b1;
    model_clear();
  endtask

  // called at a falling edge: observe cycle n, drive input for it, then advance
  task automatic run_cycle(input bit v);
    int  ph;
    bit  rise, take;
    ph = n % 4;
    fbits = {fbits[2:0], line_o};
    chk(host_irq_o == due[n % 8], "R7 pulse timing", int'(host_irq_o), int'(due[n % 8]));
    due[n % 8] = 0;
    if (host_irq_o) pulses++;
    if (ph == 3) begin
      if (cur_marker) chk(fbits == 4'b0001, "R3 marker word", int'(fbits), 1);
      else begin
        chk(is_decoy(fbits), "R6 decoy word", int'(fbits), 6);
        seen_mask[fbits] = 1'b1;
      end
    end
    acc_irq = v;
    rise = v & ~prev_v;
    prev_v = v;
    if (rise) rises_seen++;
    take = (ph == 3) && (pend > 0 || rise);
    if (ph == 3) begin
      cur_marker = take;
      if (take) begin
        due[(n + 4) % 8] = 1;
        exp_pulses++;
      end
    end
    pend = pend - (take ? 1 : 0) + (rise ? 1 : 0);
    if (pend > PEND_CAP) pend = PEND_CAP;
    n++;
    @(negedge clk);
  endtask

  initial begin
    do_reset();
    // R1: first cycle after release is phase 0, line quiet
    chk(line_o == 1'b0 && host_irq_o == 1'b0, "R1 post-release state", int'(line_o), 0);

    // table walk: each vector then an idle flush; R2 R4 R8 pulse counts
    for (int v = 0; v < NVEC; v++) begin
      int p0, r0;
      p0 = pulses;
      r0 = rises_seen;
      for (int b = 15; b >= 0; b--) run_cycle(STIM[v][b]);
      for (int f = 0; f < FLUSH; f++) run_cycle(1'b0);
      chk(rises_seen - r0 == RISES[v], "R2 event count", rises_seen - r0, RISES[v]);
      chk(pulses - p0 == RISES[v], "R8 pulse count", pulses - p0, RISES[v]);
    end

    // R6: idle frames vary
    seen_mask = '0;
    for (int f = 0; f < 64; f++) run_cycle(1'b0);
    chk($countones(seen_mask) >= 2, "R6 decoy variety", $countones(seen_mask), 2);

    // R5: burst beyond the pending capacity
    begin
      int p0, r0, e0;
      p0 = pulses; r0 = rises_seen; e0 = exp_pulses;
      for (int c = 0; c < 64; c++) run_cycle(c % 2 == 0);
      for (int f = 0; f < 80; f++) run_cycle(1'b0);
      chk(pulses - p0 == exp_pulses - e0, "R5 saturated pulse count", pulses - p0, exp_pulses - e0);
      chk(pulses - p0 < rises_seen - r0, "R5 excess dropped", pulses - p0, rises_seen - r0 - 1);
    end

    // R4: rise sampled in the phase-3 cycle is served in the very next frame
    for (int c = 0; c < 3; c++) run_cycle(1'b0);
    run_cycle(1'b1);
    for (int c = 0; c < 12; c++) run_cycle(1'b0);

    // R1: reset with events queued clears them
    for (int c = 0; c < 12; c++) run_cycle(c % 2 == 0);
    do_reset();
    begin
      int p0;
      p0 = pulses;
      for (int f = 0; f < 40; f++) run_cycle(1'b0);
      chk(pulses == p0, "R1 queue cleared by reset", pulses - p0, 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20ns * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule